// File: doc/BRIEF.md
# Spiking Neuron Firing Phase Sequencer

This block is the digital controller of a two-mode spiking neuron. It keeps the neuron in integration mode until an asynchronous threshold-crossing signal rises. It then synchronizes that signal, holds the event in a capture latch and moves the neuron into firing mode. A gap in which neither mode is enabled separates the two modes on every change.

In firing mode the block emits one spike as two phases that never overlap. A positive pulse phase comes first and a negative tail phase follows it. After the tail, one clear cycle empties the capture latch. A second gap then leads back to integration. The block also drives the switch controls that go with each mode: the membrane reset, the high-drive output stage enable and a spike-level select code. Pulse length, tail length, gap length and a tail-shape code are configuration inputs. All four are sampled when a trigger is accepted.

Top module: `neuron_phase_seq`

## Requirements
- R1: After a synchronous active-low reset, int_en_o is 1. fire_en_o, ph_pulse_o, ph_tail_o, mem_rst_o, hi_drive_o, latch_clr_o and trig_held_o are all 0, and lvl_sel_o is 00 (rest).
- R2: int_en_o and fire_en_o are never both 1. Every change between the modes is separated by D = max(cfg_dead_len_i, 1) cycles in which both are 0.
- R3: A rising edge on thr_cross_i is accepted only while int_en_o is 1. It passes two synchronizer flops and an edge detector. int_en_o falls and trig_held_o rises on the third rising clock edge after the input rises.
- R4: The pulse phase lasts P1 = max(cfg_pulse_len_i, 1) cycles, with ph_pulse_o = 1 and lvl_sel_o = 01 (high). The tail phase follows immediately and lasts P2 = max(cfg_tail_len_i, 1) cycles, with ph_tail_o = 1 and lvl_sel_o = 10 (low). The two phase strobes are never high together.
- R5: The cycle right after the tail is a clear cycle: latch_clr_o = 1, fire_en_o = 1, lvl_sel_o = 00 and trig_held_o still 1. trig_held_o is 0 from the next cycle on.
- R6: mem_rst_o is 1 from the first pulse cycle through the end of the gap before integration. It is 0 whenever int_en_o is 1.
- R7: hi_drive_o is 1 exactly in the cycles where fire_en_o is 1.
- R8: tail_shape_o equals the tail-shape code sampled at trigger acceptance while ph_tail_o is 1, and is 00 otherwise.
- R9: The configuration inputs are sampled when the trigger is accepted. Changing them during a spike has no effect on that spike.
- R10: Rising edges of thr_cross_i that occur while int_en_o is 0 are ignored and not queued. After the spike, the block stays in integration.
- R11: A thr_cross_i held high without a break produces exactly one spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_cross_i | input | 1 | Asynchronous threshold-crossing signal |
| cfg_pulse_len_i | input | 8 | Pulse phase length in cycles (0 means 1) |
| cfg_tail_len_i | input | 8 | Tail phase length in cycles (0 means 1) |
| cfg_dead_len_i | input | 4 | Mode-change gap in cycles (0 means 1) |
| cfg_tail_shape_i | input | 2 | Tail-shape code |
| int_en_o | output | 1 | Integration mode enable |
| fire_en_o | output | 1 | Firing mode enable |
| ph_pulse_o | output | 1 | Positive pulse phase strobe |
| ph_tail_o | output | 1 | Negative tail phase strobe |
| mem_rst_o | output | 1 | Ties the membrane capacitor to rest |
| hi_drive_o | output | 1 | High-drive output stage enable |
| lvl_sel_o | output | 2 | Spike level: 00 rest, 01 high, 10 low |
| tail_shape_o | output | 2 | Tail-shape code during the tail |
| latch_clr_o | output | 1 | Capture latch clear strobe |
| trig_held_o | output | 1 | Capture latch state |

## Verification
Spikes are run with distinct length sets: short odd lengths, all-zero values and long uneven lengths. This separates the clamp-to-one rule from off-by-one counting in each phase and in both gaps. A mid-spike configuration change shows whether lengths are sampled at acceptance or read live. A trigger pulse inside the gap and a trigger held high separate ignore-and-drop behaviour from queued or level-sensitive retriggering.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
    typedef enum logic [2:0] {
        ST_INTEG   = 3'd0,
        ST_DEAD_IF = 3'd1,
        ST_PULSE   = 3'd2,
        ST_TAIL    = 3'd3,
        ST_CLEAR   = 3'd4,
        ST_DEAD_FI = 3'd5
    } nsq_state_e;

    localparam logic [1:0] LVL_REST = 2'b00;
    localparam logic [1:0] LVL_HIGH = 2'b01;
    localparam logic [1:0] LVL_LOW  = 2'b10;
endpackage

// File: rtl/nsq_sync.sv
module nsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[W-2] & ~sh_q[W-1];

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/nsq_phase_fsm.sv
module nsq_phase_fsm
    import nsq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DEAD_W  = 4,
    parameter int SHAPE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_evt_i,
    input  logic [CNT_W-1:0]   cfg_pulse_i,
    input  logic [CNT_W-1:0]   cfg_tail_i,
    input  logic [DEAD_W-1:0]  cfg_dead_i,
    input  logic [SHAPE_W-1:0] cfg_shape_i,
    output nsq_state_e         state_o,
    output logic               held_o,
    output logic [SHAPE_W-1:0] shape_o
);
    typedef struct packed {
        nsq_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic               held;
        logic [CNT_W-1:0]   p1m1;
        logic [CNT_W-1:0]   p2m1;
        logic [CNT_W-1:0]   dm1;
        logic [SHAPE_W-1:0] shape;
    } seq_t;

    seq_t r_d, r_q;

    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_INTEG: begin
                if (trig_evt_i) begin
                    r_d.held  = 1'b1;
                    r_d.p1m1  = len_m1(cfg_pulse_i);
                    r_d.p2m1  = len_m1(cfg_tail_i);
                    r_d.dm1   = len_m1(CNT_W'(cfg_dead_i));
                    r_d.shape = cfg_shape_i;
                    r_d.cnt   = len_m1(CNT_W'(cfg_dead_i));
                    r_d.state = ST_DEAD_IF;
                end
            end
            ST_DEAD_IF: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_PULSE;
                    r_d.cnt   = r_q.p1m1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_TAIL;
                    r_d.cnt   = r_q.p2m1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_TAIL: begin
                if (r_q.cnt == '0) r_d.state = ST_CLEAR;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_CLEAR: begin
                r_d.held  = 1'b0;
                r_d.cnt   = r_q.dm1;
                r_d.state = ST_DEAD_FI;
            end
            ST_DEAD_FI: begin
                if (r_q.cnt == '0) r_d.state = ST_INTEG;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: r_d.state = ST_INTEG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_INTEG;
            r_q.cnt   <= '0;
            r_q.held  <= 1'b0;
            r_q.p1m1  <= '0;
            r_q.p2m1  <= '0;
            r_q.dm1   <= '0;
            r_q.shape <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign held_o  = r_q.held;
    assign shape_o = r_q.shape;

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_INTEG) |=> ($stable(r_q.p1m1) && $stable(r_q.p2m1)));

    // R10
    held_in_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PULSE || r_q.state == ST_TAIL) |-> r_q.held);
endmodule

// File: rtl/nsq_out_decode.sv
module nsq_out_decode
    import nsq_pkg::*;
#(
    parameter int SHAPE_W = 2
) (
    input  nsq_state_e         state_i,
    input  logic [SHAPE_W-1:0] shape_i,
    output logic               int_en_o,
    output logic               fire_en_o,
    output logic               ph_pulse_o,
    output logic               ph_tail_o,
    output logic               mem_rst_o,
    output logic               hi_drive_o,
    output logic [1:0]         lvl_sel_o,
    output logic [SHAPE_W-1:0] shape_o,
    output logic               latch_clr_o
);
    always_comb begin
        int_en_o    = 1'b0;
        fire_en_o   = 1'b0;
        ph_pulse_o  = 1'b0;
        ph_tail_o   = 1'b0;
        mem_rst_o   = 1'b0;
        latch_clr_o = 1'b0;
        lvl_sel_o   = LVL_REST;
        shape_o     = '0;
        unique case (state_i)
            ST_INTEG:   int_en_o = 1'b1;
            ST_DEAD_IF: ;
            ST_PULSE: begin
                fire_en_o  = 1'b1;
                ph_pulse_o = 1'b1;
                mem_rst_o  = 1'b1;
                lvl_sel_o  = LVL_HIGH;
            end
            ST_TAIL: begin
                fire_en_o = 1'b1;
                ph_tail_o = 1'b1;
                mem_rst_o = 1'b1;
                lvl_sel_o = LVL_LOW;
                shape_o   = shape_i;
            end
            ST_CLEAR: begin
                fire_en_o   = 1'b1;
                mem_rst_o   = 1'b1;
                latch_clr_o = 1'b1;
            end
            ST_DEAD_FI: mem_rst_o = 1'b1;
            default: ;
        endcase
        hi_drive_o = fire_en_o;
    end
endmodule

// File: rtl/neuron_phase_seq.sv
module neuron_phase_seq
    import nsq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DEAD_W      = 4,
    parameter int SHAPE_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               thr_cross_i,
    input  logic [CNT_W-1:0]   cfg_pulse_len_i,
    input  logic [CNT_W-1:0]   cfg_tail_len_i,
    input  logic [DEAD_W-1:0]  cfg_dead_len_i,
    input  logic [SHAPE_W-1:0] cfg_tail_shape_i,
    output logic               int_en_o,
    output logic               fire_en_o,
    output logic               ph_pulse_o,
    output logic               ph_tail_o,
    output logic               mem_rst_o,
    output logic               hi_drive_o,
    output logic [1:0]         lvl_sel_o,
    output logic [SHAPE_W-1:0] tail_shape_o,
    output logic               latch_clr_o,
    output logic               trig_held_o
);
    logic               trig_evt;
    nsq_state_e         state;
    logic [SHAPE_W-1:0] shape;

    nsq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (thr_cross_i),
        .rise_o  (trig_evt)
    );

    nsq_phase_fsm #(.CNT_W(CNT_W), .DEAD_W(DEAD_W), .SHAPE_W(SHAPE_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_evt_i  (trig_evt),
        .cfg_pulse_i (cfg_pulse_len_i),
        .cfg_tail_i  (cfg_tail_len_i),
        .cfg_dead_i  (cfg_dead_len_i),
        .cfg_shape_i (cfg_tail_shape_i),
        .state_o     (state),
        .held_o      (trig_held_o),
        .shape_o     (shape)
    );

    nsq_out_decode #(.SHAPE_W(SHAPE_W)) dec_i (
        .state_i     (state),
        .shape_i     (shape),
        .int_en_o    (int_en_o),
        .fire_en_o   (fire_en_o),
        .ph_pulse_o  (ph_pulse_o),
        .ph_tail_o   (ph_tail_o),
        .mem_rst_o   (mem_rst_o),
        .hi_drive_o  (hi_drive_o),
        .lvl_sel_o   (lvl_sel_o),
        .shape_o     (tail_shape_o),
        .latch_clr_o (latch_clr_o)
    );

    // R2
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_en_o && fire_en_o));

    // R2
    fire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire_en_o) |-> !$past(int_en_o));

    // R2
    int_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_en_o) |-> !$past(fire_en_o));

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_pulse_o && ph_tail_o));

    // R4
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_tail_o) |-> $past(ph_pulse_o));

    // R5
    latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_held_o) |-> $past(latch_clr_o));

    // R6
    mrst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_en_o |-> !mem_rst_o);

    // R7
    hidrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_drive_o |-> (mem_rst_o && trig_held_o));
endmodule

// File: tb/neuron_phase_seq_tb.sv
module neuron_phase_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr = 1'b0;
    logic [7:0] cfg_p1 = 8'd0, cfg_p2 = 8'd0;
    logic [3:0] cfg_d = 4'd0;
    logic [1:0] cfg_sh = 2'd0;
    logic       int_en, fire_en, ph1, ph2, mrst, hidrv, lclr, held;
    logic [1:0] lvl, shp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    neuron_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .thr_cross_i(thr),
        .cfg_pulse_len_i(cfg_p1), .cfg_tail_len_i(cfg_p2),
        .cfg_dead_len_i(cfg_d), .cfg_tail_shape_i(cfg_sh),
        .int_en_o(int_en), .fire_en_o(fire_en), .ph_pulse_o(ph1),
        .ph_tail_o(ph2), .mem_rst_o(mrst), .hi_drive_o(hidrv),
        .lvl_sel_o(lvl), .tail_shape_o(shp), .latch_clr_o(lclr),
        .trig_held_o(held)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // raises thr at a negedge and checks the R3 acceptance latency
    task automatic trigger(input bit keep);
        @(negedge clk);
        thr = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            if (i < 3) chk(int_en == 1'b1, "R3 early", int_en, 1);
        end
        chk(int_en == 1'b0, "R3 int_en", int_en, 0);
        chk(held == 1'b1, "R3 trig_held", held, 1);
        if (!keep) thr = 1'b0;
    endtask

    // starts in the first gap cycle and walks the spike
    task automatic walk(input int ed, input int ep1, input int ep2, input int esh);
        int n;
        n = 0;
        while (!fire_en && n < 300) begin
            chk(int_en == 1'b0, "R2 gap int", int_en, 0);
            n++;
            @(negedge clk);
        end
        chk(n == ed, "R2 gap before fire", n, ed);
        n = 0;
        while (ph1 && n < 300) begin
            chk(lvl == 2'b01, "R4 pulse lvl", lvl, 1);
            chk(hidrv == fire_en, "R7 hi_drive", hidrv, fire_en);
            chk(mrst == 1'b1, "R6 mem_rst pulse", mrst, 1);
            n++;
            @(negedge clk);
        end
        chk(n == ep1, "R4 pulse len", n, ep1);
        chk(ph2 == 1'b1, "R4 tail follows", ph2, 1);
        n = 0;
        while (ph2 && n < 300) begin
            chk(lvl == 2'b10, "R4 tail lvl", lvl, 2);
            chk(shp == 2'(esh), "R8 shape", shp, esh);
            chk(ph1 == 1'b0, "R4 no overlap", ph1, 0);
            n++;
            @(negedge clk);
        end
        chk(n == ep2, "R4 tail len", n, ep2);
        chk(lclr == 1'b1 && fire_en == 1'b1, "R5 clear cycle", lclr, 1);
        chk(lvl == 2'b00 && held == 1'b1, "R5 clear lvl/held", {lvl, held}, 1);
        chk(shp == 2'b00, "R8 shape off", shp, 0);
        @(negedge clk);
        chk(held == 1'b0, "R5 held cleared", held, 0);
        chk(hidrv == 1'b0, "R7 hi_drive off", hidrv, 0);
        n = 0;
        while (!int_en && n < 300) begin
            chk(mrst == 1'b1 && fire_en == 1'b0, "R6 mem_rst gap", mrst, 1);
            n++;
            @(negedge clk);
        end
        chk(n == ed, "R2 gap after fire", n, ed);
        chk(mrst == 1'b0, "R6 mem_rst at integ", mrst, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(int_en == 1 && fire_en == 0, "R1 modes", {int_en, fire_en}, 2);
        chk(ph1 == 0 && ph2 == 0 && lclr == 0, "R1 strobes", {ph1, ph2, lclr}, 0);
        chk(mrst == 0 && hidrv == 0 && held == 0, "R1 controls", {mrst, hidrv, held}, 0);
        chk(lvl == 2'b00, "R1 lvl", lvl, 0);
    endtask

    task automatic t_spike(input int p1, input int p2, input int d, input int sh);
        cfg_p1 = 8'(p1); cfg_p2 = 8'(p2); cfg_d = 4'(d); cfg_sh = 2'(sh);
        trigger(1'b0);
        walk((d == 0) ? 1 : d, (p1 == 0) ? 1 : p1, (p2 == 0) ? 1 : p2, sh);
    endtask

    task automatic t_cfg_change();
        cfg_p1 = 8'd4; cfg_p2 = 8'd6; cfg_d = 4'd3; cfg_sh = 2'd2;
        trigger(1'b0);
        cfg_p1 = 8'd9; cfg_p2 = 8'd1; cfg_d = 4'd7; cfg_sh = 2'd1;
        walk(3, 4, 6, 2); // R9
    endtask

    task automatic t_ignore();
        int n;
        cfg_p1 = 8'd2; cfg_p2 = 8'd2; cfg_d = 4'd10; cfg_sh = 2'd0;
        trigger(1'b0);
        @(negedge clk);
        thr = 1'b1;
        repeat (3) @(negedge clk);
        thr = 1'b0;
        n = 0;
        while (!int_en && n < 300) begin n++; @(negedge clk); end
        for (int i = 0; i < 12; i++) begin
            chk(int_en == 1'b1 && held == 1'b0, "R10 no queued spike", int_en, 1);
            @(negedge clk);
        end
    endtask

    task automatic t_hold();
        cfg_p1 = 8'd3; cfg_p2 = 8'd2; cfg_d = 4'd2; cfg_sh = 2'd3;
        trigger(1'b1);
        walk(2, 3, 2, 3);
        for (int i = 0; i < 12; i++) begin
            chk(int_en == 1'b1, "R11 single spike", int_en, 1);
            @(negedge clk);
        end
        thr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_spike(3, 5, 2, 1);
        t_spike(0, 0, 0, 2);
        t_spike(20, 41, 15, 3);
        t_cfg_change();
        t_ignore();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule